// File: doc/BRIEF.md
# MSI-X Interrupt Message Controller

The block turns interrupt requests into PCIe memory-write messages. A requester presents a vector index on a valid/ready stream. The block keeps a per-vector table that holds the message address, the message data and a mask bit, and it keeps an array of pending bits. Software reaches the table and the pending array through an AXI4-Lite slave port. When a vector can be delivered, the block puts one memory-write request on its output valid/ready interface. That request carries the 64-bit address, the 32-bit payload, the byte enables, the header size and the requester ID.

Every accepted request first sets its vector's pending bit. A scheduler picks the lowest-numbered pending vector that is currently deliverable. A vector is deliverable when the function enable is high, the global mask is low and the vector's own mask bit is clear. The scheduler copies that vector's table entry into the output register and clears its pending bit in the same edge. As a result, masked or disabled requests wait in the pending array. They are replayed in ascending index order as soon as the condition that blocked them goes away.

Back-pressure rules:
- The request input never stalls: `irq_rdy` is tied high.
- On the output, `mw_vld` and every field are held until the cycle in which `mw_rdy` is seen high. Only one message is outstanding at a time.
- The AXI4-Lite write and read responses are held until their ready signals are seen.
- A write is taken only when address and data are valid together and no write response is waiting. A read is taken only when no read response is waiting.

Top module: `msix_msg_ctrl`

## Requirements
- R1: Vector k owns the 16 bytes at byte offset 16k of the AXI4-Lite space, as four 32-bit words:
  - +0: address bits 31:0
  - +4: address bits 63:32
  - +8: message data
  - +12: control word, whose bit 0 is the vector mask (1 = masked)

  After reset every address and data word reads 0 and every control word reads 1.
- R2: A table write changes only the bytes whose strobe bit is 1 (strobe bit b covers data bits 8b+7:8b). Address bits 1:0 are ignored. A read returns the stored word.
- R3: The pending array sits at byte offset 2^(AW-1), where AW = index width + 5. Bit b of word j is the pending bit of vector 32j+b. The array is read-only: a write there is answered with response 0 (OKAY) and changes nothing. Every response code is 0.
- R4: A request for a deliverable vector, with the output free and no lower deliverable vector pending, is accepted at edge t. The message is then valid from edge t+1. It carries the entry's 64-bit address, its data word, byte enables 0xF and the `req_id` input as sampled at edge t+1.
- R5: A request whose vector is masked, globally or individually, is still accepted. It emits no message and sets the vector's pending bit.
- R6: When vectors become deliverable, the pending ones are sent lowest index first. Each pending bit clears at the edge that loads its message, so the array reads 0 once all have been sent.
- R7: While `mw_vld` is high and `mw_rdy` is low, `mw_vld` and all message fields stay unchanged. A new message loads only in a cycle where the output is empty or being accepted.
- R8: `mw_fmt4` is 1 exactly when address bits 63:32 of the message are non-zero; a 4-dword header is used then and a 3-dword header otherwise.
- R9: `irq_rdy` is always 1. `s_bvalid` and `s_rvalid` stay high, and `s_rdata` stays unchanged, until the matching ready is seen.
- R10: While `func_en` is low, requests are recorded as pending and no message is emitted. After `func_en` rises, the recorded vectors that are unmasked are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_en | input | 1 | Function-level enable for message generation |
| glob_mask | input | 1 | Global mask; 1 holds all vectors pending |
| req_id | input | 16 | Requester ID placed in each message |
| irq_vld | input | 1 | Interrupt request valid |
| irq_idx | input | IDX_W | Vector index of the request |
| irq_rdy | output | 1 | Request ready (always 1) |
| s_awaddr | input | AW | AXI4-Lite write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | AXI4-Lite read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| mw_vld | output | 1 | Memory-write message valid |
| mw_rdy | input | 1 | Memory-write message ready |
| mw_addr | output | 64 | Message target address |
| mw_data | output | 32 | Message payload, one dword |
| mw_be | output | 4 | First-dword byte enables |
| mw_fmt4 | output | 1 | 1 = 4-dword header, 0 = 3-dword header |
| mw_req_id | output | 16 | Requester ID of the message |

## Verification
Most faults in the block's state surface at the ports within a few cycles.

- A lost or stuck pending bit shows up either as a missing message or as an extra message after the next unmask. It also appears as a wrong bit in the next read of the pending array.
- A wrong selection shows up as an out-of-order payload within one cycle of the output freeing.
- Table corruption from bad strobe handling is visible in the very next read of the word. It is also visible in the address or data of the next message from that vector.
- A cycle-accurate reference compared on every clock catches any one-cycle slip in when a message appears or a response drops.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msix_msg_t;

  localparam logic [1:0] AXI_OKAY      = 2'b00;
  localparam int         WORDS_PER_VEC = 4;
  localparam int         CTRL_WORD     = 3;
  localparam int         BYTES_PER_WORD = 4;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W+1:0]       wr_word,
  input  logic [31:0]            wr_data,
  input  logic [BYTES_PER_WORD-1:0] wr_strb,
  input  logic [IDX_W+1:0]       rd_word,
  output logic [31:0]            rd_data,
  input  logic [IDX_W-1:0]       msg_sel,
  output msix_msg_t              msg_out,
  output logic [(2**IDX_W)-1:0]  vec_mask
);
  localparam int N_VEC  = 2 ** IDX_W;
  localparam int N_WORD = N_VEC * WORDS_PER_VEC;

  logic [31:0] mem [N_WORD];

  // control words come out of reset masked, all others zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < N_WORD; w++)
        mem[w] <= ((w % WORDS_PER_VEC) == CTRL_WORD) ? 32'd1 : 32'd0;
    end else if (wr_en) begin
      for (int b = 0; b < BYTES_PER_WORD; b++)
        if (wr_strb[b]) mem[wr_word][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data      = mem[rd_word];
  assign msg_out.addr = {mem[{msg_sel, 2'd1}], mem[{msg_sel, 2'd0}]};
  assign msg_out.data = mem[{msg_sel, 2'd2}];

  for (genvar g = 0; g < N_VEC; g++) begin : g_mask
    assign vec_mask[g] = mem[g*WORDS_PER_VEC + CTRL_WORD][0];
  end
endmodule

// File: rtl/msix_axil.sv
module msix_axil
  import msix_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W+4:0]      s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [31:0]           s_wdata,
  input  logic [3:0]            s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [IDX_W+4:0]      s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [31:0]           s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic                  tbl_we,
  output logic [IDX_W+1:0]      tbl_wword,
  output logic [31:0]           tbl_wdata,
  output logic [3:0]            tbl_wstrb,
  output logic [IDX_W+1:0]      tbl_rword,
  input  logic [31:0]           tbl_rdata,
  input  logic [(2**IDX_W)-1:0] pend
);
  localparam int AW        = IDX_W + 5;
  localparam int N_VEC     = 2 ** IDX_W;
  localparam int PBA_WORDS = (N_VEC + 31) / 32;

  logic wr_go, rd_go;
  logic [31:0] pba_val, rd_val;
  logic [PBA_WORDS*32-1:0] pba_pad;
  logic unused_low_bits;

  assign unused_low_bits = ^{s_awaddr[1:0], s_araddr[1:0]};

  // a write needs both channels and a free response slot
  assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign tbl_we    = wr_go && !s_awaddr[AW-1];
  assign tbl_wword = s_awaddr[AW-2:2];
  assign tbl_wdata = s_wdata;
  assign tbl_wstrb = s_wstrb;

  assign rd_go     = s_arvalid && !s_rvalid;
  assign s_arready = !s_rvalid;
  assign tbl_rword = s_araddr[AW-2:2];

  always_comb begin
    pba_pad = '0;
    pba_pad[N_VEC-1:0] = pend;
    pba_val = '0;
    for (int k = 0; k < PBA_WORDS; k++)
      if (int'(s_araddr[AW-2:2]) == k) pba_val = pba_pad[k*32 +: 32];
  end

  assign rd_val  = s_araddr[AW-1] ? pba_val : tbl_rdata;
  assign s_bresp = AXI_OKAY;
  assign s_rresp = AXI_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_go)         s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (rd_go) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_val;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid); // R9
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R9
endmodule

// File: rtl/msix_sched.sv
module msix_sched
  import msix_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  irq_vld,
  input  logic [IDX_W-1:0]      irq_idx,
  output logic                  irq_rdy,
  input  logic                  func_en,
  input  logic                  glob_mask,
  input  logic [(2**IDX_W)-1:0] vec_mask,
  input  logic [15:0]           req_id,
  output logic [(2**IDX_W)-1:0] pend,
  output logic [IDX_W-1:0]      msg_sel,
  input  msix_msg_t             msg_in,
  output logic                  mw_vld,
  input  logic                  mw_rdy,
  output logic [63:0]           mw_addr,
  output logic [31:0]           mw_data,
  output logic                  mw_fmt4,
  output logic [15:0]           mw_req_id
);
  localparam int N_VEC = 2 ** IDX_W;

  logic [N_VEC-1:0] elig, pend_nxt;
  logic             sel_vld, issue;
  logic [IDX_W-1:0] sel;

  assign irq_rdy = 1'b1;
  assign elig    = pend & ~vec_mask & {N_VEC{func_en && !glob_mask}};

  // lowest index wins
  always_comb begin
    sel_vld = 1'b0;
    sel     = '0;
    for (int i = N_VEC - 1; i >= 0; i--)
      if (elig[i]) begin
        sel_vld = 1'b1;
        sel     = IDX_W'(i);
      end
  end

  assign msg_sel = sel;
  assign issue   = sel_vld && (!mw_vld || mw_rdy);

  // a fresh request wins over the clear of the same vector
  always_comb begin
    pend_nxt = pend;
    if (issue)   pend_nxt[sel]     = 1'b0;
    if (irq_vld) pend_nxt[irq_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      mw_vld    <= 1'b0;
      mw_addr   <= '0;
      mw_data   <= '0;
      mw_fmt4   <= 1'b0;
      mw_req_id <= '0;
    end else begin
      pend <= pend_nxt;
      if (issue) begin
        mw_vld    <= 1'b1;
        mw_addr   <= msg_in.addr;
        mw_data   <= msg_in.data;
        mw_fmt4   <= |msg_in.addr[63:32];
        mw_req_id <= req_id;
      end else if (mw_rdy) begin
        mw_vld <= 1'b0;
      end
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mw_vld && !mw_rdy |=> mw_vld); // R7
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    mw_vld && !mw_rdy |=> $stable(mw_addr) && $stable(mw_data) && $stable(mw_req_id)); // R7
  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vld && irq_rdy |=> pend[$past(irq_idx)]); // R5
  AST_FMT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mw_vld |-> (mw_fmt4 == (mw_addr[63:32] != 32'd0))); // R8
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_vld) |-> $past(func_en) && !$past(glob_mask)); // R10
endmodule

// File: rtl/msix_msg_ctrl.sv
module msix_msg_ctrl
  import msix_pkg::*;
#(
  parameter  int IDX_W = 3,
  localparam int AW    = IDX_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             glob_mask,
  input  logic [15:0]      req_id,
  input  logic             irq_vld,
  input  logic [IDX_W-1:0] irq_idx,
  output logic             irq_rdy,
  input  logic [AW-1:0]    s_awaddr,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [31:0]      s_wdata,
  input  logic [3:0]       s_wstrb,
  input  logic             s_wvalid,
  output logic             s_wready,
  output logic [1:0]       s_bresp,
  output logic             s_bvalid,
  input  logic             s_bready,
  input  logic [AW-1:0]    s_araddr,
  input  logic             s_arvalid,
  output logic             s_arready,
  output logic [31:0]      s_rdata,
  output logic [1:0]       s_rresp,
  output logic             s_rvalid,
  input  logic             s_rready,
  output logic             mw_vld,
  input  logic             mw_rdy,
  output logic [63:0]      mw_addr,
  output logic [31:0]      mw_data,
  output logic [3:0]       mw_be,
  output logic             mw_fmt4,
  output logic [15:0]      mw_req_id
);
  localparam int N_VEC = 2 ** IDX_W;

  logic             tbl_we;
  logic [IDX_W+1:0] tbl_wword, tbl_rword;
  logic [31:0]      tbl_wdata, tbl_rdata;
  logic [3:0]       tbl_wstrb;
  logic [N_VEC-1:0] pend, vec_mask;
  logic [IDX_W-1:0] msg_sel;
  msix_msg_t        msg;

  assign mw_be = 4'hF;

  msix_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_word(tbl_wword), .wr_data(tbl_wdata), .wr_strb(tbl_wstrb),
    .rd_word(tbl_rword), .rd_data(tbl_rdata),
    .msg_sel(msg_sel), .msg_out(msg), .vec_mask(vec_mask)
  );

  msix_axil #(.IDX_W(IDX_W)) u_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .tbl_we(tbl_we), .tbl_wword(tbl_wword), .tbl_wdata(tbl_wdata), .tbl_wstrb(tbl_wstrb),
    .tbl_rword(tbl_rword), .tbl_rdata(tbl_rdata), .pend(pend)
  );

  msix_sched #(.IDX_W(IDX_W)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .irq_vld(irq_vld), .irq_idx(irq_idx), .irq_rdy(irq_rdy),
    .func_en(func_en), .glob_mask(glob_mask), .vec_mask(vec_mask), .req_id(req_id),
    .pend(pend), .msg_sel(msg_sel), .msg_in(msg),
    .mw_vld(mw_vld), .mw_rdy(mw_rdy), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_fmt4(mw_fmt4), .mw_req_id(mw_req_id)
  );
endmodule

// File: tb/sim_msix_msg_ctrl.sv
module sim_msix_msg_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  IW   = 3;
  localparam int  NV   = 8;
  localparam int  AWD  = 8;
  localparam real TCLK = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_en = 1'b0, glob_mask = 1'b0;
  logic [15:0] req_id = 16'h0A5C;
  logic irq_vld = 1'b0;
  logic [IW-1:0] irq_idx = '0;
  logic irq_rdy;
  logic [AWD-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
  logic [31:0] s_wdata = '0, s_rdata;
  logic [3:0] s_wstrb = '0;
  logic [1:0] s_bresp, s_rresp;
  logic s_bready = 1'b1, s_rready = 1'b1, mw_rdy = 1'b1;
  logic mw_vld, mw_fmt4;
  logic [63:0] mw_addr;
  logic [31:0] mw_data;
  logic [3:0] mw_be;
  logic [15:0] mw_req_id;

  int n_tests = 0, n_fail = 0;
  int bp_mode = 0, bp_cnt = 0;
  bit stall = 1'b0, started = 1'b0;
  int rx_q[$], exp_q[$];

  // reference state
  logic [31:0] m_tbl [NV*4];
  logic [NV-1:0] m_pend;
  logic m_ovld, m_bv, m_rv;
  logic [63:0] m_oaddr;
  logic [31:0] m_odata, m_rd;
  logic [15:0] m_oreq;
  int m_s;

  always #(TCLK/2) clk = ~clk;

  msix_msg_ctrl #(.IDX_W(IW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [AWD-1:0] a);
    if (!a[AWD-1]) return m_tbl[a[AWD-2:2]];
    if (a[AWD-2:2] == 0) return {{(32-NV){1'b0}}, m_pend};
    return 32'd0;
  endfunction

  // cycle reference: same edge as the design, inputs stable since the negedge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NV*4; w++) m_tbl[w] = (w % 4 == 3) ? 32'd1 : 32'd0;
      m_pend = '0; m_ovld = 0; m_bv = 0; m_rv = 0;
      m_oaddr = '0; m_odata = '0; m_oreq = '0; m_rd = '0;
    end else begin
      if (s_arvalid && !m_rv) begin m_rd = mread(s_araddr); m_rv = 1; end
      else if (m_rv && s_rready) m_rv = 0;
      if (!m_ovld || mw_rdy) begin
        m_s = -1;
        if (func_en && !glob_mask)
          for (int i = 0; i < NV; i++)
            if (m_s < 0 && m_pend[i] && !m_tbl[i*4+3][0]) m_s = i;
        if (m_s >= 0) begin
          m_ovld = 1;
          m_oaddr = {m_tbl[m_s*4+1], m_tbl[m_s*4]};
          m_odata = m_tbl[m_s*4+2];
          m_oreq = req_id;
          m_pend[m_s] = 1'b0;
        end else m_ovld = 0;
      end
      if (irq_vld) m_pend[irq_idx] = 1'b1;
      if (s_awvalid && s_wvalid && !m_bv) begin
        if (!s_awaddr[AWD-1])
          for (int b = 0; b < 4; b++)
            if (s_wstrb[b]) m_tbl[s_awaddr[AWD-2:2]][8*b +: 8] = s_wdata[8*b +: 8];
        m_bv = 1;
      end else if (m_bv && s_bready) m_bv = 0;
    end
  end

  always @(posedge clk) if (rst_n && mw_vld && mw_rdy) rx_q.push_back(int'(mw_data));

  // compare every cycle, then update the ready pattern
  always @(negedge clk) begin
    if (started) begin
      chk(irq_rdy == 1'b1, "R9 irq_rdy", irq_rdy, 1);
      chk(mw_vld == m_ovld, "R4 mw_vld", mw_vld, m_ovld);
      if (m_ovld) begin
        chk(mw_addr == m_oaddr, "R4 mw_addr", mw_addr, m_oaddr);
        chk(mw_data == m_odata, "R4 mw_data", mw_data, m_odata);
        chk(mw_req_id == m_oreq, "R4 mw_req_id", mw_req_id, m_oreq);
        chk(mw_be == 4'hF, "R4 mw_be", mw_be, 4'hF);
        chk(mw_fmt4 == (m_oaddr[63:32] != 0), "R8 mw_fmt4", mw_fmt4, m_oaddr[63:32] != 0);
      end
      chk(s_bvalid == m_bv, "R9 s_bvalid", s_bvalid, m_bv);
      chk(s_rvalid == m_rv, "R9 s_rvalid", s_rvalid, m_rv);
      if (m_rv) chk(s_rdata == m_rd, "R1 s_rdata", s_rdata, m_rd);
    end
    bp_cnt++;
    mw_rdy   <= !stall && (bp_mode == 0 || (bp_cnt % 4) != 3);
    s_bready <= (bp_mode == 0 || (bp_cnt % 3) != 1);
    s_rready <= (bp_mode == 0 || (bp_cnt % 5) != 2);
  end

  task automatic axw(input logic [AWD-1:0] a, input logic [31:0] d, input logic [3:0] st);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
    #1; while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk); s_awvalid = 0; s_wvalid = 0;
    #1; while (!(s_bvalid && s_bready)) begin @(negedge clk); #1; end
    chk(s_bresp == 2'b00, "R3 bresp", s_bresp, 0);
    @(negedge clk);
  endtask

  task automatic axr(input logic [AWD-1:0] a, output logic [31:0] d);
    s_araddr = a; s_arvalid = 1;
    #1; while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk); s_arvalid = 0;
    #1; while (!(s_rvalid && s_rready)) begin @(negedge clk); #1; end
    d = s_rdata;
    chk(s_rresp == 2'b00, "R3 rresp", s_rresp, 0);
    @(negedge clk);
  endtask

  task automatic irq(input int i);
    irq_idx = IW'(i); irq_vld = 1; @(negedge clk); irq_vld = 0;
  endtask

  task automatic settle(); repeat (40) @(negedge clk); endtask

  task automatic check_rx(input string tag);
    chk(rx_q.size() == exp_q.size(), {tag, " count"}, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++)
      if (i < rx_q.size()) chk(rx_q[i] == exp_q[i], {tag, " order"}, rx_q[i], exp_q[i]);
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic rd_chk(input logic [AWD-1:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    axr(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(TCLK * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1; started = 1;
    @(negedge clk);
    // R1 / R3 reset state
    chk(mw_vld == 1'b0, "R4 idle after reset", mw_vld, 0);
    rd_chk(8'h0C, 32'd1, "R1 reset ctrl masked");
    rd_chk(8'h08, 32'd0, "R1 reset data");
    rd_chk(8'h80, 32'd0, "R3 reset pending");

    bp_mode = 1;
    for (int k = 0; k < NV; k++) begin
      axw(AWD'(k*16),     32'h1000 + k*4, 4'hF);
      axw(AWD'(k*16 + 4), (k % 2) ? 32'h12345678 : 32'd0, 4'hF);
      axw(AWD'(k*16 + 8), 32'hA0 + k, 4'hF);
      axw(AWD'(k*16 + 12), 32'd0, 4'hF);
    end
    rd_chk(8'h14, 32'h12345678, "R1 high address word");

    // R2 strobes and unaligned address
    axw(8'h78, 32'hFFFFFFFF, 4'hF);
    axw(8'h7B, 32'h11223344, 4'b0110);
    rd_chk(8'h78, 32'hFF2233FF, "R2 partial strobe");
    rd_chk(8'h74, 32'h12345678, "R2 neighbour untouched");
    axw(8'h78, 32'h000000A7, 4'hF);

    // R4 unmasked delivery
    func_en = 1;
    for (int k = 0; k < NV; k++) irq(k);
    settle();
    for (int k = 0; k < NV; k++) exp_q.push_back(32'hA0 + k);
    check_rx("R4 unmasked");
    rd_chk(8'h80, 32'd0, "R6 pending empty");

    // R5 / R6 global mask, requests sent in descending order
    glob_mask = 1;
    for (int k = NV-1; k >= 0; k--) irq(k);
    settle();
    check_rx("R5 global mask silent");
    rd_chk(8'h80, 32'hFF, "R5 pending set");
    glob_mask = 0;
    settle();
    for (int k = 0; k < NV; k++) exp_q.push_back(32'hA0 + k);
    check_rx("R6 ascending replay");
    rd_chk(8'h80, 32'd0, "R6 pending cleared");

    // R5 / R3 vector masks and read-only pending array
    axw(8'h2C, 32'd1, 4'hF);
    axw(8'h5C, 32'd1, 4'hF);
    irq(5); irq(2); irq(3);
    settle();
    exp_q.push_back(32'hA3);
    check_rx("R5 vector mask");
    rd_chk(8'h80, 32'h24, "R5 vector pending");
    axw(8'h80, 32'hFFFFFFFF, 4'hF);
    axw(8'h80, 32'h00000000, 4'hF);
    rd_chk(8'h80, 32'h24, "R3 pending write ignored");
    settle();
    check_rx("R3 no message after pending write");
    axw(8'h5C, 32'd0, 4'hF);
    settle();
    exp_q.push_back(32'hA5);
    check_rx("R6 unmask vector 5");
    axw(8'h2C, 32'd0, 4'hF);
    settle();
    exp_q.push_back(32'hA2);
    check_rx("R6 unmask vector 2");

    // R10 function disabled
    func_en = 0; req_id = 16'h0101;
    irq(6); irq(1);
    settle();
    check_rx("R10 disabled silent");
    rd_chk(8'h80, 32'h42, "R10 pending while disabled");
    func_en = 1;
    settle();
    exp_q.push_back(32'hA1); exp_q.push_back(32'hA6);
    check_rx("R10 sent after enable");

    // R7 stall holds the message
    stall = 1;
    irq(0); irq(1);
    repeat (5) @(negedge clk);
    chk(mw_vld == 1'b1, "R7 valid held", mw_vld, 1);
    chk(mw_data == 32'hA0, "R7 data held", mw_data, 32'hA0);
    repeat (10) @(negedge clk);
    chk(mw_vld == 1'b1 && mw_data == 32'hA0, "R7 still held", mw_data, 32'hA0);
    rd_chk(8'h80, 32'h02, "R7 second waits pending");
    stall = 0;
    settle();
    exp_q.push_back(32'hA0); exp_q.push_back(32'hA1);
    check_rx("R7 after stall");

    summary();
  end
endmodule